// File: doc/BRIEF.md
# PHY Power-Up and Reset Sequencer

This block brings a combined USB 2 / USB 3 PHY and the controller behind it out of reset in a fixed order. After a start request it holds every reset, picks a reference-clock path from a status input, takes the PHY out of its low-power test states and releases the PHY resets. After a timed wait it reports stable power rails, configures the type-C mux and turns on spread-spectrum clocking. It then releases the controller-side resets, waits again, forces VBUS-valid on both bus paths, waits a third time and asks an external tuning block to run.

A successful tuning result raises a ready flag. A tuning failure parks the sequencer in an error state with a sticky flag. A stop request from the ready or error state runs a short power-down path. That path first puts the PHY back in reset and then switches off the clock source that the start sequence turned on. Each wait is a cycle count derived from a clock-frequency parameter and a duration in microseconds.

Top module: `phy_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the following values hold. All four reset outputs are 0. `iddq_o`, `u3_tpd_o`, `refclk_iso_o` and `clk_mux_o` are 1. `refclk_sel_o` is 2'b00. Every other output is 0, including `ready_o` and `err_o`.
- R2: A start request sampled in the idle state drives all four active-low resets (`aux_rst_n_o`, `ctrl_rst_n_o`, `u3phy_rst_n_o`, `u2por_n_o`) to 0 at that edge. The clock path is configured on the following edge.
- R3: If `pad_clk_sel_i` is 0 at the configuration edge, the internal path is used. `refclk_iso_o` goes to 0, `osc_en_o` to 1, `clk_mux_o` to 0 and `u2_refsel_o` to 0, and `refclk_sel_o` is set to 2'b11.
- R4: If `pad_clk_sel_i` is 1 at the configuration edge, the pad path is used. `use_pad_o` goes to 1, `u2_refsel_o` to 1 and `refgate_en_o` to 1, and `refclk_sel_o` is set to 2'b10.
- R5: One edge after the clock configuration, `iddq_o` and `u3_tpd_o` fall to 0. On the edge after that, `u3phy_rst_n_o` and `u2por_n_o` rise together.
- R6: Exactly WAIT = CLK_MHZ*WAIT_US cycles after the PHY resets rise, `ana_pwr_en_o`, `pcs_stable_o` and `pma_stable_o` rise together. `tcmux_cfg_o` follows one cycle later and `ssc_en_o` one cycle after that.
- R7: One cycle after `ssc_en_o`, `aux_rst_n_o` and `ctrl_rst_n_o` rise, always after the PHY resets. WAIT cycles later, `u3_vbus_o`, `u3_vbus_ovr_o`, `u2_vbus_o` and `u2_vbus_ovr_o` rise together.
- R8: WAIT cycles after the VBUS overrides, `tune_req_o` rises. It stays high until `tune_done_i` or `tune_err_i` is sampled.
- R9: When `tune_done_i` is sampled with `tune_req_o` high, `tune_req_o` falls and `ready_o` rises on that edge. `ready_o` is never high before the whole sequence has completed.
- R10: When `tune_err_i` is sampled with `tune_req_o` high, `tune_req_o` falls and `err_o` rises, and `ready_o` stays 0. `tune_err_i` takes precedence over `tune_done_i`. `err_o` stays 1 until `rst_n` is asserted.
- R11: A start request is ignored while a sequence runs, while the tuning result is pending, and in the ready, error or power-down states. No output changes because of it.
- R12: A stop request in the ready or error state drives `u3phy_rst_n_o` and `u2por_n_o` to 0 and `ready_o` to 0 on that edge. On the next edge, `osc_en_o` falls (internal path) or `refgate_en_o` falls (pad path). The block then returns to idle, and a later start request is accepted.
- R13: A stop request at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the bring-up sequence |
| stop_i | input | 1 | Request to run the power-down path |
| pad_clk_sel_i | input | 1 | 1 selects the pad reference clock, 0 the internal source |
| tune_done_i | input | 1 | Tuning step finished without error |
| tune_err_i | input | 1 | Tuning step reported a failure |
| aux_rst_n_o | output | 1 | Auxiliary reset, active low |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| u3phy_rst_n_o | output | 1 | USB3 PHY reset, active low |
| u2por_n_o | output | 1 | USB2 PHY power-on reset, active low |
| iddq_o | output | 1 | USB2 PHY IDDQ (quiescent) mode |
| u3_tpd_o | output | 1 | USB3 PHY test power-down |
| refclk_iso_o | output | 1 | Reference-clock isolation enable |
| osc_en_o | output | 1 | Internal oscillator enable |
| clk_mux_o | output | 1 | Reference-clock mux select |
| u2_refsel_o | output | 1 | USB2 PHY reference-clock select |
| refclk_sel_o | output | 2 | Reference-clock select code (2'b11 internal, 2'b10 pad) |
| use_pad_o | output | 1 | USB3 PHY uses the pad reference |
| refgate_en_o | output | 1 | Reference-clock gate open |
| ana_pwr_en_o | output | 1 | Analog power enable |
| pcs_stable_o | output | 1 | PCS power-stable indication |
| pma_stable_o | output | 1 | PMA power-stable indication |
| tcmux_cfg_o | output | 1 | Type-C mux configuration enable |
| ssc_en_o | output | 1 | Spread-spectrum clocking enable |
| u3_vbus_o | output | 1 | Forced USB3 VBUS-valid value |
| u3_vbus_ovr_o | output | 1 | USB3 VBUS-valid override select |
| u2_vbus_o | output | 1 | Forced USB2 VBUS-valid value |
| u2_vbus_ovr_o | output | 1 | USB2 VBUS-valid override select |
| tune_req_o | output | 1 | Request to the tuning block |
| ready_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sticky tuning failure flag |

## Verification
The assertions assume that `pad_clk_sel_i` is stable at the clock-configuration edge. They also assume that `tune_done_i` and `tune_err_i` carry meaning only while `tune_req_o` is high. The bench changes the path select only while the block is idle and pulses the tuning inputs for one cycle after it sees the request. The wait-length checks assume at least one cycle of WAIT. The bench uses a one-microsecond wait at the default clock frequency, so every timed window is a few hundred cycles long and the arithmetic is the same as in the full-length case.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLK, ST_PWR, ST_PREL, ST_W1, ST_MUX, ST_SSC,
    ST_CREL, ST_W2, ST_W3, ST_TUNE, ST_READY, ST_ERR, ST_SHUT
  } seq_state_t;

  typedef struct packed {
    logic       iso;
    logic       osc;
    logic       mux;
    logic       u2sel;
    logic [1:0] sel;
    logic       pad;
    logic       gate;
  } clk_cfg_t;

  localparam logic [1:0] SEL_INTERNAL = 2'b11;
  localparam logic [1:0] SEL_PAD      = 2'b10;
  localparam clk_cfg_t   CLK_CFG_RST  = '{iso: 1'b1, osc: 1'b0, mux: 1'b1,
                                          u2sel: 1'b0, sel: 2'b00,
                                          pad: 1'b0, gate: 1'b0};

  // Cycles in one timed wait.
  function automatic int unsigned wait_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  // Clock settings for the chosen path.
  function automatic clk_cfg_t clk_bring_up(clk_cfg_t c, logic pad_path);
    clk_cfg_t r = c;
    if (!pad_path) begin
      r.iso   = 1'b0;
      r.osc   = 1'b1;
      r.mux   = 1'b0;
      r.u2sel = 1'b0;
      r.sel   = SEL_INTERNAL;
    end else begin
      r.pad   = 1'b1;
      r.u2sel = 1'b1;
      r.sel   = SEL_PAD;
      r.gate  = 1'b1;
    end
    return r;
  endfunction

  // Switch off the source that the path enabled.
  function automatic clk_cfg_t clk_take_down(clk_cfg_t c, logic pad_path);
    clk_cfg_t r = c;
    if (!pad_path) r.osc  = 1'b0;
    else           r.gate = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int unsigned CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load_i)        cnt <= CW'(CYCLES - 1);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/phy_seq_clkpath.sv
module phy_seq_clkpath
  import phy_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     apply_i,
  input  logic     shut_i,
  input  logic     pad_i,
  output clk_cfg_t cfg_o
);
  logic pad_path;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o    <= CLK_CFG_RST;
      pad_path <= 1'b0;
    end else if (apply_i) begin
      cfg_o    <= clk_bring_up(cfg_o, pad_i);
      pad_path <= pad_i;
    end else if (shut_i) begin
      cfg_o    <= clk_take_down(cfg_o, pad_path);
    end
  end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned WAIT_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       pad_clk_sel_i,
  input  logic       tune_done_i,
  input  logic       tune_err_i,
  output logic       aux_rst_n_o,
  output logic       ctrl_rst_n_o,
  output logic       u3phy_rst_n_o,
  output logic       u2por_n_o,
  output logic       iddq_o,
  output logic       u3_tpd_o,
  output logic       refclk_iso_o,
  output logic       osc_en_o,
  output logic       clk_mux_o,
  output logic       u2_refsel_o,
  output logic [1:0] refclk_sel_o,
  output logic       use_pad_o,
  output logic       refgate_en_o,
  output logic       ana_pwr_en_o,
  output logic       pcs_stable_o,
  output logic       pma_stable_o,
  output logic       tcmux_cfg_o,
  output logic       ssc_en_o,
  output logic       u3_vbus_o,
  output logic       u3_vbus_ovr_o,
  output logic       u2_vbus_o,
  output logic       u2_vbus_ovr_o,
  output logic       tune_req_o,
  output logic       ready_o,
  output logic       err_o
);
  localparam int unsigned WAIT_CYC = wait_cycles(CLK_MHZ, WAIT_US);

  seq_state_t st;
  clk_cfg_t   ccfg;

  // Named internal events.
  logic in_idle, phy_rel_evt, ctl_rel_evt, wait_done, tmr_load, stop_taken;

  assign in_idle     = (st == ST_IDLE);
  assign phy_rel_evt = (st == ST_PREL);
  assign ctl_rel_evt = (st == ST_CREL);
  assign stop_taken  = stop_i && ((st == ST_READY) || (st == ST_ERR));
  assign tmr_load    = phy_rel_evt || ctl_rel_evt || ((st == ST_W2) && wait_done);

  phy_seq_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .done_o (wait_done)
  );

  phy_seq_clkpath u_clkpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .apply_i (st == ST_CLK),
    .shut_i  (st == ST_SHUT),
    .pad_i   (pad_clk_sel_i),
    .cfg_o   (ccfg)
  );

  assign refclk_iso_o = ccfg.iso;
  assign osc_en_o     = ccfg.osc;
  assign clk_mux_o    = ccfg.mux;
  assign u2_refsel_o  = ccfg.u2sel;
  assign refclk_sel_o = ccfg.sel;
  assign use_pad_o    = ccfg.pad;
  assign refgate_en_o = ccfg.gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      aux_rst_n_o   <= 1'b0;
      ctrl_rst_n_o  <= 1'b0;
      u3phy_rst_n_o <= 1'b0;
      u2por_n_o     <= 1'b0;
      iddq_o        <= 1'b1;
      u3_tpd_o      <= 1'b1;
      ana_pwr_en_o  <= 1'b0;
      pcs_stable_o  <= 1'b0;
      pma_stable_o  <= 1'b0;
      tcmux_cfg_o   <= 1'b0;
      ssc_en_o      <= 1'b0;
      u3_vbus_o     <= 1'b0;
      u3_vbus_ovr_o <= 1'b0;
      u2_vbus_o     <= 1'b0;
      u2_vbus_ovr_o <= 1'b0;
      tune_req_o    <= 1'b0;
      ready_o       <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_i) begin
          aux_rst_n_o   <= 1'b0;
          ctrl_rst_n_o  <= 1'b0;
          u3phy_rst_n_o <= 1'b0;
          u2por_n_o     <= 1'b0;
          st            <= ST_CLK;
        end
        ST_CLK: st <= ST_PWR;
        ST_PWR: begin
          iddq_o   <= 1'b0;
          u3_tpd_o <= 1'b0;
          st       <= ST_PREL;
        end
        ST_PREL: begin
          u3phy_rst_n_o <= 1'b1;
          u2por_n_o     <= 1'b1;
          st            <= ST_W1;
        end
        ST_W1: if (wait_done) begin
          ana_pwr_en_o <= 1'b1;
          pcs_stable_o <= 1'b1;
          pma_stable_o <= 1'b1;
          st           <= ST_MUX;
        end
        ST_MUX: begin
          tcmux_cfg_o <= 1'b1;
          st          <= ST_SSC;
        end
        ST_SSC: begin
          ssc_en_o <= 1'b1;
          st       <= ST_CREL;
        end
        ST_CREL: begin
          aux_rst_n_o  <= 1'b1;
          ctrl_rst_n_o <= 1'b1;
          st           <= ST_W2;
        end
        ST_W2: if (wait_done) begin
          u3_vbus_o     <= 1'b1;
          u3_vbus_ovr_o <= 1'b1;
          u2_vbus_o     <= 1'b1;
          u2_vbus_ovr_o <= 1'b1;
          st            <= ST_W3;
        end
        ST_W3: if (wait_done) begin
          tune_req_o <= 1'b1;
          st         <= ST_TUNE;
        end
        ST_TUNE: begin
          if (tune_err_i) begin
            tune_req_o <= 1'b0;
            err_o      <= 1'b1;
            st         <= ST_ERR;
          end else if (tune_done_i) begin
            tune_req_o <= 1'b0;
            ready_o    <= 1'b1;
            st         <= ST_READY;
          end
        end
        ST_READY, ST_ERR: if (stop_taken) begin
          u3phy_rst_n_o <= 1'b0;
          u2por_n_o     <= 1'b0;
          ready_o       <= 1'b0;
          st            <= ST_SHUT;
        end
        ST_SHUT: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk #(
  parameter int unsigned W_CYC = 25000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_idle,
  input logic       aux_rst_n_o,
  input logic       ctrl_rst_n_o,
  input logic       u3phy_rst_n_o,
  input logic       u2por_n_o,
  input logic       iddq_o,
  input logic       u3_tpd_o,
  input logic       refclk_iso_o,
  input logic       osc_en_o,
  input logic [1:0] refclk_sel_o,
  input logic       use_pad_o,
  input logic       refgate_en_o,
  input logic       pma_stable_o,
  input logic       ssc_en_o,
  input logic       u3_vbus_o,
  input logic       u2_vbus_o,
  input logic       tune_req_o,
  input logic       ready_o,
  input logic       err_o
);
  // Cycles since the PHY resets last rose.
  logic [31:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap <= '0;
    else if ($rose(u3phy_rst_n_o)) gap <= 32'd1;
    else if (gap != '0)          gap <= gap + 32'd1;
  end

  assert_phy_rel_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(u3phy_rst_n_o) |-> (!iddq_o && !u3_tpd_o && u2por_n_o));

  assert_clk_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(u3phy_rst_n_o) |->
      ((osc_en_o && !refclk_iso_o && refclk_sel_o == 2'b11) ||
       (refgate_en_o && use_pad_o && refclk_sel_o == 2'b10)));

  assert_wait_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pma_stable_o) |-> (gap == W_CYC));

  assert_ctrl_after_phy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n_o) |-> (u3phy_rst_n_o && u2por_n_o && ssc_en_o && aux_rst_n_o));

  assert_tune_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tune_req_o && ready_o));

  assert_ready_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (aux_rst_n_o && ctrl_rst_n_o && u3phy_rst_n_o && u2por_n_o &&
                 pma_stable_o && u3_vbus_o && u2_vbus_o));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_rst_n_o) |-> $past(in_idle));

  assert_stop_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> (!u3phy_rst_n_o && !u2por_n_o));
endmodule

bind phy_bringup_seq phy_bringup_chk #(.W_CYC(WAIT_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_idle       (in_idle),
  .aux_rst_n_o   (aux_rst_n_o),
  .ctrl_rst_n_o  (ctrl_rst_n_o),
  .u3phy_rst_n_o (u3phy_rst_n_o),
  .u2por_n_o     (u2por_n_o),
  .iddq_o        (iddq_o),
  .u3_tpd_o      (u3_tpd_o),
  .refclk_iso_o  (refclk_iso_o),
  .osc_en_o      (osc_en_o),
  .refclk_sel_o  (refclk_sel_o),
  .use_pad_o     (use_pad_o),
  .refgate_en_o  (refgate_en_o),
  .pma_stable_o  (pma_stable_o),
  .ssc_en_o      (ssc_en_o),
  .u3_vbus_o     (u3_vbus_o),
  .u2_vbus_o     (u2_vbus_o),
  .tune_req_o    (tune_req_o),
  .ready_o       (ready_o),
  .err_o         (err_o)
);

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
  localparam int CLKM = 250;
  localparam int WUS  = 1;
  localparam int W    = CLKM * WUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, pad_clk_sel_i = 1'b0;
  logic tune_done_i = 1'b0, tune_err_i = 1'b0;

  logic aux_rst_n_o, ctrl_rst_n_o, u3phy_rst_n_o, u2por_n_o, iddq_o, u3_tpd_o;
  logic refclk_iso_o, osc_en_o, clk_mux_o, u2_refsel_o, use_pad_o, refgate_en_o;
  logic [1:0] refclk_sel_o;
  logic ana_pwr_en_o, pcs_stable_o, pma_stable_o, tcmux_cfg_o, ssc_en_o;
  logic u3_vbus_o, u3_vbus_ovr_o, u2_vbus_o, u2_vbus_ovr_o;
  logic tune_req_o, ready_o, err_o;

  always #2 clk = ~clk;

  phy_bringup_seq #(.CLK_MHZ(CLKM), .WAIT_US(WUS)) i_phy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .pad_clk_sel_i(pad_clk_sel_i), .tune_done_i(tune_done_i), .tune_err_i(tune_err_i),
    .aux_rst_n_o(aux_rst_n_o), .ctrl_rst_n_o(ctrl_rst_n_o),
    .u3phy_rst_n_o(u3phy_rst_n_o), .u2por_n_o(u2por_n_o), .iddq_o(iddq_o),
    .u3_tpd_o(u3_tpd_o), .refclk_iso_o(refclk_iso_o), .osc_en_o(osc_en_o),
    .clk_mux_o(clk_mux_o), .u2_refsel_o(u2_refsel_o), .refclk_sel_o(refclk_sel_o),
    .use_pad_o(use_pad_o), .refgate_en_o(refgate_en_o), .ana_pwr_en_o(ana_pwr_en_o),
    .pcs_stable_o(pcs_stable_o), .pma_stable_o(pma_stable_o),
    .tcmux_cfg_o(tcmux_cfg_o), .ssc_en_o(ssc_en_o), .u3_vbus_o(u3_vbus_o),
    .u3_vbus_ovr_o(u3_vbus_ovr_o), .u2_vbus_o(u2_vbus_o), .u2_vbus_ovr_o(u2_vbus_ovr_o),
    .tune_req_o(tune_req_o), .ready_o(ready_o), .err_o(err_o)
  );

  // Behavioural timeline model: elapsed edges since the accepted start.
  logic m_aux, m_ctl, m_u3r, m_u2r, m_iddq, m_tpd, m_iso, m_osc, m_mux, m_u2s;
  logic [1:0] m_sel;
  logic m_pad, m_gate, m_ana, m_pcs, m_pma, m_tcm, m_ssc;
  logic m_v3, m_v3o, m_v2, m_v2o, m_treq, m_rdy, m_err;
  int mode, cyc, t0, el;
  logic path_pad;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_aux, m_ctl, m_u3r, m_u2r} = 4'b0000;
      m_iddq = 1; m_tpd = 1; m_iso = 1; m_osc = 0; m_mux = 1; m_u2s = 0;
      m_sel = 2'b00; m_pad = 0; m_gate = 0;
      {m_ana, m_pcs, m_pma, m_tcm, m_ssc} = '0;
      {m_v3, m_v3o, m_v2, m_v2o} = '0;
      m_treq = 0; m_rdy = 0; m_err = 0;
      mode = 0; cyc = 0; t0 = 0; path_pad = 0;
    end else begin
      cyc++;
      el = cyc - t0;
      case (mode)
        0: if (start_i) begin
             {m_aux, m_ctl, m_u3r, m_u2r} = 4'b0000; t0 = cyc; mode = 1;
           end
        1: begin
             if (el == 1) begin
               path_pad = pad_clk_sel_i;
               if (!path_pad) begin m_iso = 0; m_osc = 1; m_mux = 0; m_u2s = 0; m_sel = 2'b11; end
               else begin m_pad = 1; m_u2s = 1; m_sel = 2'b10; m_gate = 1; end
             end
             if (el == 2) begin m_iddq = 0; m_tpd = 0; end
             if (el == 3) begin m_u3r = 1; m_u2r = 1; end
             if (el == 3 + W) begin m_ana = 1; m_pcs = 1; m_pma = 1; end
             if (el == 4 + W) m_tcm = 1;
             if (el == 5 + W) m_ssc = 1;
             if (el == 6 + W) begin m_aux = 1; m_ctl = 1; end
             if (el == 6 + 2*W) begin m_v3 = 1; m_v3o = 1; m_v2 = 1; m_v2o = 1; end
             if (el == 6 + 3*W) begin m_treq = 1; mode = 2; end
           end
        2: if (tune_err_i) begin m_treq = 0; m_err = 1; mode = 4; end
           else if (tune_done_i) begin m_treq = 0; m_rdy = 1; mode = 3; end
        3, 4: if (stop_i) begin m_u3r = 0; m_u2r = 0; m_rdy = 0; mode = 5; end
        5: begin
             if (!path_pad) m_osc = 0; else m_gate = 0;
             mode = 0;
           end
        default: mode = 0;
      endcase
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  function automatic logic [26:0] got_vec();
    return {aux_rst_n_o, ctrl_rst_n_o, u3phy_rst_n_o, u2por_n_o, iddq_o, u3_tpd_o,
            refclk_iso_o, osc_en_o, clk_mux_o, u2_refsel_o, refclk_sel_o, use_pad_o,
            refgate_en_o, ana_pwr_en_o, pcs_stable_o, pma_stable_o, tcmux_cfg_o,
            ssc_en_o, u3_vbus_o, u3_vbus_ovr_o, u2_vbus_o, u2_vbus_ovr_o,
            tune_req_o, ready_o, err_o};
  endfunction

  function automatic logic [26:0] exp_vec();
    return {m_aux, m_ctl, m_u3r, m_u2r, m_iddq, m_tpd, m_iso, m_osc, m_mux, m_u2s,
            m_sel, m_pad, m_gate, m_ana, m_pcs, m_pma, m_tcm, m_ssc,
            m_v3, m_v3o, m_v2, m_v2o, m_treq, m_rdy, m_err};
  endfunction

  task automatic check_eq(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // One cycle: wait to the falling edge, compare all outputs to the model.
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_chk++;
      if (got_vec() !== exp_vec()) begin
        n_fail++;
        $display("FAIL %s: outputs got %h expected %h", cur_req, got_vec(), exp_vec());
      end
    end
  endtask

  // Edge-time recorder for the timing checks.
  int t_phy, t_pma, t_ctl, t_vbus, t_req, ncyc;
  logic p_phy, p_pma, p_ctl, p_vbus, p_req;
  initial begin
    ncyc = 0; p_phy = 0; p_pma = 0; p_ctl = 0; p_vbus = 0; p_req = 0;
    t_phy = 0; t_pma = 0; t_ctl = 0; t_vbus = 0; t_req = 0;
    forever begin
      @(negedge clk);
      ncyc++;
      if (u3phy_rst_n_o && !p_phy) t_phy = ncyc;
      if (pma_stable_o && !p_pma) t_pma = ncyc;
      if (ctrl_rst_n_o && !p_ctl) t_ctl = ncyc;
      if (u3_vbus_o && !p_vbus) t_vbus = ncyc;
      if (tune_req_o && !p_req) t_req = ncyc;
      p_phy = u3phy_rst_n_o; p_pma = pma_stable_o; p_ctl = ctrl_rst_n_o;
      p_vbus = u3_vbus_o; p_req = tune_req_o;
    end
  end

  task automatic wait_req();
    for (int i = 0; i < 4*W + 50 && !tune_req_o; i++) tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1"; tick(3);
    rst_n = 1'b1; tick(2);
    check_eq("R1", {iddq_o, u3_tpd_o, clk_mux_o, refclk_iso_o}, 4'hF);
    check_eq("R1", {ready_o, err_o, aux_rst_n_o, u3phy_rst_n_o}, 0);

    // Internal path run
    pad_clk_sel_i = 1'b0; start_i = 1'b1; cur_req = "R2"; tick();
    start_i = 1'b0; cur_req = "R3"; tick(2);
    check_eq("R3", refclk_sel_o, 3);
    cur_req = "R5"; tick(2);
    check_eq("R5", u3phy_rst_n_o, 1);
    start_i = 1'b1; cur_req = "R11"; tick(); start_i = 1'b0;
    stop_i = 1'b1; cur_req = "R13"; tick(); stop_i = 1'b0;
    cur_req = "R6"; wait_req();
    check_eq("R6", t_pma - t_phy, W);
    check_eq("R7", t_vbus - t_ctl, W);
    check_eq("R7", (t_ctl > t_phy) ? 1 : 0, 1);
    check_eq("R8", t_req - t_vbus, W);
    cur_req = "R8"; tick(4);
    check_eq("R8", tune_req_o, 1);
    tune_done_i = 1'b1; cur_req = "R9"; tick(); tune_done_i = 1'b0;
    check_eq("R9", {ready_o, tune_req_o}, 2);
    start_i = 1'b1; cur_req = "R11"; tick(2); start_i = 1'b0;
    check_eq("R11", ready_o, 1);
    stop_i = 1'b1; cur_req = "R12"; tick(); stop_i = 1'b0;
    check_eq("R12", {ready_o, u3phy_rst_n_o, osc_en_o}, 1);
    tick();
    check_eq("R12", osc_en_o, 0);
    tick(2);

    // Pad path run
    pad_clk_sel_i = 1'b1; start_i = 1'b1; cur_req = "R2"; tick();
    start_i = 1'b0; check_eq("R2", {aux_rst_n_o, ctrl_rst_n_o}, 0);
    cur_req = "R4"; tick();
    check_eq("R4", {use_pad_o, u2_refsel_o, refgate_en_o, refclk_sel_o}, 5'b11110);
    wait_req();
    tick(2); tune_done_i = 1'b1; cur_req = "R9"; tick(); tune_done_i = 1'b0;
    stop_i = 1'b1; cur_req = "R12"; tick(); stop_i = 1'b0;
    tick();
    check_eq("R12", refgate_en_o, 0);
    tick(2);

    // Error run: err wins over done, sticky, start ignored
    pad_clk_sel_i = 1'b0; start_i = 1'b1; cur_req = "R10"; tick(); start_i = 1'b0;
    wait_req();
    tune_err_i = 1'b1; tune_done_i = 1'b1; tick();
    tune_err_i = 1'b0; tune_done_i = 1'b0;
    check_eq("R10", {err_o, ready_o}, 2);
    start_i = 1'b1; cur_req = "R11"; tick(3); start_i = 1'b0;
    stop_i = 1'b1; cur_req = "R12"; tick(); stop_i = 1'b0;
    tick(3);
    check_eq("R10", err_o, 1);
    rst_n = 1'b0; cur_req = "R1"; tick(2);
    check_eq("R1", err_o, 0);
    rst_n = 1'b1; tick(2);

    finish_run();
  end
endmodule